// File: doc/BRIEF.md
# Dual-Slope / Single-Slope 16-bit PWM Timer

This block is a 16-bit timer that produces pulse-width modulated waveforms on two output pins. A prescaler turns the system clock into a timer tick. On each tick the counter advances in one of two shapes. In single-slope (fast) mode it ramps up and then clears. In dual-slope (phase-correct) mode it ramps up to the top value and then back down to zero. The top value comes from one of three places, chosen by the waveform field: a plain top register, the active value of compare channel A, or one of three fixed values (0x00FF, 0x01FF, 0x03FF) in dual-slope mode.

Software writes the control word, the top register and the two compare registers through one write port. Compare A is double-buffered: a write lands in a holding register, and the live value takes it on the tick where the counter sits at the top value. The top register is not buffered. A sticky overflow flag marks the end of each counting cycle, and a write clears it.

Top module: `pwm16_timer`

## Requirements
- R1: After reset `count` is 0, both pins are low and `ovf_flag` is 0. Every register is 0 and the timer is stopped.
- R2: Control bits [5:3] select the tick rate. A value of 1, 2, 3, 4 or 5 gives one tick every 1, 8, 64, 256 or 1024 clocks. Values 0, 6 and 7 stop the counter. The counter moves only on a tick.
- R3: Control bits [2:0] select the waveform. Value 0 (and 7) is fast mode with TOP from the top register (address 1). Value 1 is fast mode with TOP from active compare A. In fast mode the count runs 0..TOP, then clears to 0 on the next tick, and that tick sets `ovf_flag`.
- R4: A write to address 2 updates only the compare A buffer. The active compare A value, which also serves as TOP in waveforms 1 and 6, takes the buffer contents on the tick where `count` equals TOP while counting up.
- R5: The top register (address 1) takes effect at once. If it is written below the current count, the counter runs on to 0xFFFF, wraps to 0, and only then meets the new TOP.
- R6: Output mode 2 (non-inverting) sets the pin on the TOP tick and clears it on the tick where `count` equals the channel's compare value. In fast mode the pin is high for cmp+1 of every TOP+1 ticks. Mode 3 gives the complement. Channel A's mode is control bits [7:6]; channel B's is bits [9:8]. Compare B (address 3) is unbuffered.
- R7: In fast mode a compare value of 0 gives a one-tick high spike per period in mode 2. A compare value equal to TOP gives a constant level: high in mode 2, low in mode 3.
- R8: Output mode 1 toggles pin A on every compare match, but only when TOP comes from compare A (waveform 1 or 6). Under any other waveform, and on channel B, mode 1 holds the pin low.
- R9: Waveforms 2, 3 and 4 are dual-slope with TOP 0x00FF, 0x01FF and 0x03FF. Waveform 5 takes TOP from the top register and waveform 6 from active compare A. The count goes 0..TOP..0, a period of 2*TOP ticks. `ovf_flag` sets on the tick where the count turns at 0.
- R10: In dual-slope mode, mode 2 clears the pin on a match while rising and sets it on a match while falling. The tick at count 0 counts as rising and the tick at TOP counts as falling. The pin is high for 2*cmp of 2*TOP ticks: a compare of 0 gives constant low and a compare of TOP gives constant high. Mode 3 is the complement.
- R11: Output mode 0 holds the pin low.
- R12: Writing 1 to bit 0 at address 4 clears `ovf_flag`. If an overflow event happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 control, 1 top, 2 compare A buffer, 3 compare B, 4 flag clear |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| oc_a | output | 1 | Compare channel A pin |
| oc_b | output | 1 | Compare channel B pin |
| ovf_flag | output | 1 | Sticky end-of-cycle flag |

## Verification
Both channels are run with mid-range, zero and at-TOP compare values in both slope shapes. Measuring high-time over whole periods separates the non-inverting, inverting, spike and constant cases, and a clear-versus-set priority error shows up as a wrong count. Compare A is rewritten in mid-cycle while it also sets TOP, which shows whether the update waits for the top tick. A top register written below the running count must produce a visit to 0xFFFF. A behavioural model is compared on every clock against count, pins and flag, so any deviation in the turn points, tick rates or flag timing is reported.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

   typedef enum logic [1:0] {
      OC_OFF    = 2'd0,
      OC_TOGGLE = 2'd1,
      OC_NONINV = 2'd2,
      OC_INV    = 2'd3
   } oc_mode_e;

   typedef enum logic [2:0] {
      WV_FAST_REG  = 3'd0,
      WV_FAST_CMPA = 3'd1,
      WV_PC_8BIT   = 3'd2,
      WV_PC_9BIT   = 3'd3,
      WV_PC_10BIT  = 3'd4,
      WV_PC_REG    = 3'd5,
      WV_PC_CMPA   = 3'd6,
      WV_FAST_ALT  = 3'd7
   } wave_e;

   typedef struct packed {
      oc_mode_e oc_b;
      oc_mode_e oc_a;
      logic [2:0] clk_sel;
      wave_e wave;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);

   localparam logic [2:0] ADR_CTRL  = 3'd0;
   localparam logic [2:0] ADR_TOP   = 3'd1;
   localparam logic [2:0] ADR_CMPA  = 3'd2;
   localparam logic [2:0] ADR_CMPB  = 3'd3;
   localparam logic [2:0] ADR_FLAG  = 3'd4;

endpackage

// File: rtl/pwm16_prescale.sv
module pwm16_prescale #(
   parameter int DIV_BITS = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);
   localparam int STEP1 = 3;
   localparam int STEP2 = 6;
   localparam int STEP3 = 8;
   localparam int STEP4 = 10;

   if (DIV_BITS < STEP4) begin : g_bad_div
      $error("pwm16_prescale: DIV_BITS must be at least 10");
   end

   logic [DIV_BITS-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
   end

   always_comb begin
      case (sel)
         3'd1:    tick = 1'b1;
         3'd2:    tick = &phase_q[STEP1-1:0];
         3'd3:    tick = &phase_q[STEP2-1:0];
         3'd4:    tick = &phase_q[STEP3-1:0];
         3'd5:    tick = &phase_q[STEP4-1:0];
         default: tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/pwm16_count.sv
module pwm16_count
   import pwm16_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  wave_e            wave,
   input  logic [WIDTH-1:0] top_reg,
   input  logic [WIDTH-1:0] cmpa_buf,
   output logic [WIDTH-1:0] cnt,
   output logic [WIDTH-1:0] cmpa_act,
   output logic [WIDTH-1:0] top_val,
   output logic             phase,
   output logic             top_hit,
   output logic             down_slope,
   output logic             ovf_evt
);
   localparam logic [WIDTH-1:0] TOP8  = WIDTH'(16'h00FF);
   localparam logic [WIDTH-1:0] TOP9  = WIDTH'(16'h01FF);
   localparam logic [WIDTH-1:0] TOP10 = WIDTH'(16'h03FF);

   logic dir_down;
   logic bottom;

   always_comb begin
      case (wave)
         WV_FAST_CMPA, WV_PC_CMPA: top_val = cmpa_act;
         WV_PC_8BIT:               top_val = TOP8;
         WV_PC_9BIT:               top_val = TOP9;
         WV_PC_10BIT:              top_val = TOP10;
         default:                  top_val = top_reg;
      endcase
   end

   assign phase   = (wave == WV_PC_8BIT) || (wave == WV_PC_9BIT) || (wave == WV_PC_10BIT)
                 || (wave == WV_PC_REG)  || (wave == WV_PC_CMPA);
   assign top_hit = (cnt == top_val);
   assign bottom  = (cnt == '0);
   assign down_slope = phase && ((top_hit && !bottom) || (!bottom && dir_down));
   assign ovf_evt = tick && (phase ? (bottom && (dir_down || top_hit)) : top_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         dir_down <= 1'b0;
         cmpa_act <= '0;
      end else if (tick) begin
         if (top_hit && !dir_down) cmpa_act <= cmpa_buf;
         if (!phase) begin
            dir_down <= 1'b0;
            cnt      <= top_hit ? '0 : cnt + 1'b1;
         end else if (dir_down) begin
            if (bottom) begin
               dir_down <= 1'b0;
               cnt      <= (top_val == '0) ? '0 : WIDTH'(1);
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else if (top_hit) begin
            if (!bottom) begin
               dir_down <= 1'b1;
               cnt      <= cnt - 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwm16_ocu.sv
module pwm16_ocu
   import pwm16_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit CAN_TOGGLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  oc_mode_e         mode,
   input  logic [WIDTH-1:0] cnt,
   input  logic [WIDTH-1:0] cmp,
   input  logic             phase,
   input  logic             top_hit,
   input  logic             down_slope,
   input  logic             top_from_a,
   output logic             pin
);
   logic level_q;
   logic toggle_ok;
   logic match;

   if (CAN_TOGGLE) begin : g_tog
      assign toggle_ok = top_from_a;
   end else begin : g_notog
      assign toggle_ok = 1'b0;
   end

   assign match = (cnt == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= 1'b0;
      end else if (tick) begin
         case (mode)
            OC_TOGGLE: if (toggle_ok && match) level_q <= !level_q;
            OC_NONINV, OC_INV: begin
               if (phase) begin
                  if (match) level_q <= down_slope ? (mode == OC_NONINV) : (mode == OC_INV);
               end else if (top_hit) begin
                  level_q <= (mode == OC_NONINV);
               end else if (match) begin
                  level_q <= (mode == OC_INV);
               end
            end
            default: level_q <= level_q;
         endcase
      end
   end

   assign pin = (mode == OC_OFF || (mode == OC_TOGGLE && !toggle_ok)) ? 1'b0 : level_q;
endmodule

// File: rtl/pwm16_timer.sv
module pwm16_timer
   import pwm16_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int DIV_BITS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] count,
   output logic             oc_a,
   output logic             oc_b,
   output logic             ovf_flag
);
   localparam int NUM_CH = 2;

   if (WIDTH < CTRL_BITS) begin : g_bad_width
      $error("pwm16_timer: WIDTH must hold the control word and 10-bit fixed tops");
   end

   ctrl_t            ctrl_q;
   logic [WIDTH-1:0] top_reg_q;
   logic [WIDTH-1:0] cmpa_buf_q;
   logic [WIDTH-1:0] cmpb_q;
   logic             tick;
   logic [WIDTH-1:0] cmpa_act;
   logic [WIDTH-1:0] top_val;
   logic             phase;
   logic             top_hit;
   logic             down_slope;
   logic             ovf_evt;
   logic             top_from_a;
   logic [WIDTH-1:0] ch_cmp  [NUM_CH];
   oc_mode_e         ch_mode [NUM_CH];
   logic             ch_pin  [NUM_CH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         top_reg_q  <= '0;
         cmpa_buf_q <= '0;
         cmpb_q     <= '0;
         ovf_flag   <= 1'b0;
      end else begin
         if (wr_en) begin
            case (wr_addr)
               ADR_CTRL: ctrl_q     <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
               ADR_TOP:  top_reg_q  <= wr_data;
               ADR_CMPA: cmpa_buf_q <= wr_data;
               ADR_CMPB: cmpb_q     <= wr_data;
               default: ;
            endcase
         end
         if (ovf_evt)                                      ovf_flag <= 1'b1;
         else if (wr_en && wr_addr == ADR_FLAG && wr_data[0]) ovf_flag <= 1'b0;
      end
   end

   pwm16_prescale #(.DIV_BITS(DIV_BITS)) i_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (ctrl_q.clk_sel),
      .tick (tick)
   );

   pwm16_count #(.WIDTH(WIDTH)) i_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wave      (ctrl_q.wave),
      .top_reg   (top_reg_q),
      .cmpa_buf  (cmpa_buf_q),
      .cnt       (count),
      .cmpa_act  (cmpa_act),
      .top_val   (top_val),
      .phase     (phase),
      .top_hit   (top_hit),
      .down_slope(down_slope),
      .ovf_evt   (ovf_evt)
   );

   assign top_from_a = (ctrl_q.wave == WV_FAST_CMPA) || (ctrl_q.wave == WV_PC_CMPA);
   assign ch_cmp[0]  = cmpa_act;
   assign ch_cmp[1]  = cmpb_q;
   assign ch_mode[0] = ctrl_q.oc_a;
   assign ch_mode[1] = ctrl_q.oc_b;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      pwm16_ocu #(.WIDTH(WIDTH), .CAN_TOGGLE(ch == 0)) i_ocu (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .mode      (ch_mode[ch]),
         .cnt       (count),
         .cmp       (ch_cmp[ch]),
         .phase     (phase),
         .top_hit   (top_hit),
         .down_slope(down_slope),
         .top_from_a(top_from_a),
         .pin       (ch_pin[ch])
      );
   end

   assign oc_a = ch_pin[0];
   assign oc_b = ch_pin[1];
endmodule

// File: rtl/pwm16_checks.sv
module pwm16_checks #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             phase,
   input logic [WIDTH-1:0] count,
   input logic [WIDTH-1:0] top_val,
   input logic [WIDTH-1:0] cmpa_act,
   input logic             ovf_flag,
   input logic             oc_a,
   input logic [1:0]       mode_a
);
   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   assert_fast_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !phase && count == top_val) |=> (count == '0));

   assert_fast_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !phase && count == top_val) |=> ovf_flag);

   assert_buffer_at_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmpa_act) |-> $past(tick && count == top_val));

   assert_step_or_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !phase && count != top_val) |=> (count == WIDTH'($past(count) + 1'b1)));

   assert_turn_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && phase && count == top_val && count != '0) |=> (count == WIDTH'($past(count) - 1'b1)));

   assert_off_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_a == 2'd0) |-> !oc_a);
endmodule

bind pwm16_timer pwm16_checks #(.WIDTH(WIDTH)) u_pwm16_checks (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .phase   (phase),
   .count   (count),
   .top_val (top_val),
   .cmpa_act(cmpa_act),
   .ovf_flag(ovf_flag),
   .oc_a    (oc_a),
   .mode_a  (ctrl_q.oc_a)
);

// File: tb/test_pwm16_timer.sv
`timescale 1ns/1ps
module test_pwm16_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] count;
   logic        oc_a, oc_b, ovf_flag;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit cmp_on = 1'b0;
   string tag = "R1";

   always #2 clk = !clk;

   pwm16_timer i_pwm16_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .count(count), .oc_a(oc_a), .oc_b(oc_b), .ovf_flag(ovf_flag)
   );

   // behavioural reference model
   int m_pc, m_wave, m_sel, m_ma, m_mb, m_top, m_bufa, m_acta, m_cmpb, m_cnt;
   bit m_dir, m_qa, m_qb, m_flag;

   function automatic int top_of(int wave, int topr, int acta);
      case (wave)
         1, 6: return acta;
         2: return 255;
         3: return 511;
         4: return 1023;
         default: return topr;
      endcase
   endfunction

   function automatic bit next_level(int md, bit q, bit tog, int cnt, int cmp, int top,
                                     bit ph, bit dn);
      if (md == 1) return (tog && cnt == cmp) ? !q : q;
      if (md < 2) return q;
      if (ph) return (cnt == cmp) ? (dn ? (md == 2) : (md == 3)) : q;
      if (cnt == top) return md == 2;
      if (cnt == cmp) return md == 3;
      return q;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_pc = 0; m_wave = 0; m_sel = 0; m_ma = 0; m_mb = 0; m_top = 0; m_bufa = 0;
         m_acta = 0; m_cmpb = 0; m_cnt = 0; m_dir = 0; m_qa = 0; m_qb = 0; m_flag = 0;
      end else begin
         bit tk, ph, hit, dn, ev, tog;
         int top, ncnt, nacta;
         case (m_sel)
            1: tk = 1;
            2: tk = (m_pc % 8) == 7;
            3: tk = (m_pc % 64) == 63;
            4: tk = (m_pc % 256) == 255;
            5: tk = (m_pc % 1024) == 1023;
            default: tk = 0;
         endcase
         top = top_of(m_wave, m_top, m_acta);
         ph  = (m_wave >= 2 && m_wave <= 6);
         hit = (m_cnt == top);
         dn  = ph && ((hit && m_cnt != 0) || (m_cnt != 0 && m_dir));
         tog = (m_wave == 1 || m_wave == 6);
         ev = 0; ncnt = m_cnt; nacta = m_acta;
         if (tk) begin
            m_qa = next_level(m_ma, m_qa, tog, m_cnt, m_acta, top, ph, dn);
            m_qb = next_level(m_mb, m_qb, 1'b0, m_cnt, m_cmpb, top, ph, dn);
            if (hit && !m_dir) nacta = m_bufa;
            if (!ph) begin
               ev = hit; ncnt = hit ? 0 : (m_cnt + 1) % 65536; m_dir = 0;
            end else if (m_dir) begin
               if (m_cnt == 0) begin ev = 1; m_dir = 0; ncnt = (top == 0) ? 0 : 1; end
               else ncnt = m_cnt - 1;
            end else if (hit) begin
               if (m_cnt == 0) ev = 1;
               else begin m_dir = 1; ncnt = m_cnt - 1; end
            end else ncnt = (m_cnt + 1) % 65536;
         end
         m_cnt = ncnt; m_acta = nacta;
         if (ev) m_flag = 1;
         else if (wr_en && wr_addr == 4 && wr_data[0]) m_flag = 0;
         if (wr_en) begin
            case (wr_addr)
               0: begin m_wave = wr_data[2:0]; m_sel = wr_data[5:3];
                        m_ma = wr_data[7:6]; m_mb = wr_data[9:8]; end
               1: m_top = wr_data;
               2: m_bufa = wr_data;
               3: m_cmpb = wr_data;
               default: ;
            endcase
         end
         m_pc = (m_pc + 1) % 1024;
      end
   end

   task automatic chk(string req, int act, int exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         n_chk++;
         if (count !== 16'(m_cnt) || oc_a !== m_qa_pin() || oc_b !== m_qb_pin()
             || ovf_flag !== m_flag) begin
            n_fail++;
            $display("FAIL %s model: actual cnt=%0d a=%b b=%b f=%b expected cnt=%0d a=%b b=%b f=%b",
                     tag, count, oc_a, oc_b, ovf_flag, m_cnt, m_qa_pin(), m_qb_pin(), m_flag);
         end
      end
   end

   function automatic bit m_qa_pin();
      if (m_ma == 0 || (m_ma == 1 && !(m_wave == 1 || m_wave == 6))) return 0;
      return m_qa;
   endfunction
   function automatic bit m_qb_pin();
      if (m_mb < 2) return 0;
      return m_qb;
   endfunction

   always @(posedge clk) begin
      if (cyc == 190000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic ctrl(int wave, int sel, int ma, int mb);
      wr(0, (mb << 8) | (ma << 6) | (sel << 3) | wave);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; cmp_on = 0;
      step(4);
      rst_n = 1; cmp_on = 1;
   endtask

   task automatic high_time(int n, output int ha, output int hb);
      ha = 0; hb = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ha += oc_a; hb += oc_b;
      end
   endtask

   task automatic wait_count(int v, int lim, output bit seen);
      seen = 0;
      for (int i = 0; i < lim && !seen; i++) begin
         @(negedge clk);
         if (count == 16'(v)) seen = 1;
      end
   endtask

   task automatic max_count(int n, output int mx);
      mx = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (count > mx) mx = count;
      end
   endtask

   initial begin
      int ha, hb, mx, ch, prev, c1;
      bit seen;
      do_reset();
      step(1);
      // R1: reset state
      chk("R1", count, 0, "count"); chk("R1", oc_a, 0, "oc_a");
      chk("R1", oc_b, 0, "oc_b");   chk("R1", ovf_flag, 0, "flag");

      // R6: fast non-inverting / inverting, TOP 9, cmp 3
      tag = "R6";
      wr(1, 9); wr(2, 3); wr(3, 3);
      ctrl(0, 1, 2, 3);
      step(30); high_time(100, ha, hb);
      chk("R6", ha, 40, "noninv high"); chk("R6", hb, 60, "inv high");

      // R7: extremes
      tag = "R7";
      wr(2, 0); wr(3, 9);
      step(30); high_time(100, ha, hb);
      chk("R7", ha, 10, "spike high"); chk("R7", hb, 0, "inv at TOP");
      ctrl(0, 1, 2, 2);
      step(30); high_time(100, ha, hb);
      chk("R7", hb, 100, "noninv at TOP");

      // R11 / R8: off and toggle without compare-A top
      tag = "R11";
      ctrl(0, 1, 0, 2);
      step(5); high_time(50, ha, hb);
      chk("R11", ha, 0, "off pin");
      tag = "R8";
      ctrl(0, 1, 1, 1);
      step(5); high_time(50, ha, hb);
      chk("R8", ha, 0, "toggle w/o A top"); chk("R8", hb, 0, "toggle on B");

      // R8: toggle with TOP = compare A = 4
      wr(2, 4);
      step(20);
      ctrl(1, 1, 1, 0);
      step(30); high_time(100, ha, hb);
      chk("R8", ha, 50, "toggle 50% high");

      // R4: buffered compare A as TOP
      tag = "R4";
      wait_count(1, 100, seen);
      wr(2, 7);
      mx = 0;
      for (int i = 0; i < 20 && count != 0; i++) begin
         if (count > mx) mx = count;
         @(negedge clk);
      end
      chk("R4", mx, 4, "old TOP before load");
      max_count(8, mx);
      chk("R4", mx, 7, "new TOP after load");

      // R2: prescaler /8 then stopped
      tag = "R2";
      ctrl(0, 2, 0, 0);
      ch = 0; prev = count;
      for (int i = 0; i < 800; i++) begin
         @(negedge clk);
         if (count != prev) ch++;
         prev = count;
      end
      chk("R2", ch, 100, "steps in 800 clocks");
      ctrl(0, 0, 0, 0);
      ch = 0; prev = count;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (count != prev) ch++;
         prev = count;
      end
      chk("R2", ch, 0, "steps while stopped");

      // R12: flag clear
      tag = "R12";
      chk("R12", ovf_flag, 1, "flag set");
      wr(4, 1);
      chk("R12", ovf_flag, 0, "flag cleared");

      // R5: late top write forces full wrap
      tag = "R5";
      wr(1, 1000);
      ctrl(0, 1, 0, 0);
      wait_count(600, 2000, seen);
      wr(1, 100);
      wait_count(65535, 70000, seen);
      chk("R5", seen, 1, "reached 0xFFFF");
      wait_count(0, 10, seen);
      max_count(300, mx);
      chk("R5", mx, 100, "new TOP after wrap");

      // R3: fast period 101 ticks between flags
      tag = "R3";
      wait_count(100, 200, seen);
      wr(4, 1);
      wait_count(100, 200, seen);
      step(1);
      chk("R3", count, 0, "clear after TOP");
      chk("R3", ovf_flag, 1, "flag at TOP");

      // R10: dual-slope, TOP 9
      do_reset();
      tag = "R10";
      wr(1, 9); wr(2, 3); wr(3, 3);
      ctrl(5, 1, 2, 3);
      step(40); high_time(180, ha, hb);
      chk("R10", ha, 60, "noninv high"); chk("R10", hb, 120, "inv high");
      wr(2, 0); wr(3, 9);
      ctrl(5, 1, 2, 2);
      step(40); high_time(180, ha, hb);
      chk("R10", ha, 0, "cmp 0 constant low"); chk("R10", hb, 180, "cmp TOP constant high");

      // R9: fixed tops and flag period
      tag = "R9";
      ctrl(2, 1, 0, 0);
      max_count(600, mx);
      chk("R9", mx, 255, "8-bit top");
      wr(4, 1);
      while (!ovf_flag) @(negedge clk);
      c1 = cyc;
      wr(4, 1);
      while (!ovf_flag) @(negedge clk);
      chk("R9", cyc - c1, 510, "flag period");
      ctrl(3, 1, 0, 0);
      max_count(1100, mx);
      chk("R9", mx, 511, "9-bit top");
      ctrl(4, 1, 0, 0);
      max_count(2200, mx);
      chk("R9", mx, 1023, "10-bit top");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule